// File: doc/BRIEF.md
# Debug Arm and Trigger Control Register

This block is the 8-bit control register at the front of an on-chip debug and trace unit. Software writes it over a simple register bus. Those writes arm the unit, choose the break behaviour and the comparator bank, and request an immediate trigger. Hardware can disarm the unit on its own: when a trace session finishes, or when a breakpoint is taken while tracing is off. A hardware disarm wins over a software write in the same cycle.

While the unit is armed, the four configuration bits are frozen. Only the arm bit, the trigger bit and the bank select still accept writes. Because of this, a write that clears the arm bit cannot change the configuration bits in that same write; clearing them takes a second write. The trigger bit is write-only and always reads back as 0. A write of 1 to it produces a one-cycle trigger request, unless secure mode is on or a begin- or middle-aligned trace is already in progress. A small stub tracks the trace status so that this last rule can be exercised. Arming the unit sends a one-cycle pulse that puts the state sequencer into State1.

Top module: `dbg_arm_ctl`

## Requirements
- R1: After a synchronous active-low reset, the arm flag, configuration bits, bank select, trigger pulse, State1 pulse and trace-running flag are all 0.
- R2: While `reg_sel_i` is 1, `reg_rdata_o` is {arm, 0, cfg[3:0], bank[1:0]} in the same cycle, with bit 6 always 0. While `reg_sel_i` is 0, `reg_rdata_o` is 0.
- R3: A write (`reg_sel_i` and `reg_wr_i` both 1) loads bit 7 of the write data into the arm flag, which shows on `armed_o` from the next cycle.
- R4: A write loads bits 5:2 into `cfg_o` only if the arm flag was 0 before the write. It loads bits 1:0 into `bank_o` whatever the arm flag is.
- R5: A write that clears the arm flag while armed leaves `cfg_o` unchanged. A second write, made while disarmed, can then change it.
- R6: When `trace_done_i` or `brk_notrace_i` is 1, the arm flag is 0 in the next cycle, even if a write of arm=1 happens in the same cycle.
- R7: `seq_s1_o` is 1 for exactly the first cycle in which `armed_o` is 1 after having been 0. It is never 1 at any other time.
- R8: A write with bit 6 set gives a one-cycle `trig_req_o` pulse in the next cycle. A write with bit 6 clear gives no pulse.
- R9: While `secure_i` is 1, a write with bit 6 set gives no trigger pulse.
- R10: A trigger that fires while `trc_en_i` is 1 and `trc_align_i` is 01 (begin) or 10 (middle) sets `trc_running_o` in the next cycle. Alignment 00 (end) does not set it. While `trc_running_o` is 1, writes to bit 6 give no pulse.
- R11: `trc_running_o` clears in the cycle after `trace_done_i`, or in the cycle after the arm flag goes to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| reg_sel_i | input | 1 | Register select |
| reg_wr_i | input | 1 | Write strobe, valid while selected |
| reg_wdata_i | input | 8 | Write data |
| reg_rdata_o | output | 8 | Read data, combinational |
| trace_done_i | input | 1 | Trace session complete (hardware disarm) |
| brk_notrace_i | input | 1 | Breakpoint taken with tracing off (hardware disarm) |
| secure_i | input | 1 | Secure mode, blocks the trigger |
| trc_en_i | input | 1 | Trace source enabled |
| trc_align_i | input | 2 | Trigger alignment: 00 end, 01 begin, 10 middle |
| armed_o | output | 1 | Arm flag |
| trig_req_o | output | 1 | One-cycle immediate trigger request |
| seq_s1_o | output | 1 | One-cycle pulse that sends the sequencer to State1 |
| cfg_o | output | 4 | Break enables and break-mode select |
| bank_o | output | 2 | Comparator bank select |
| trc_running_o | output | 1 | Trace-in-progress stub flag |

## Verification
The bench builds the block with its default widths: four configuration bits and a two-bit bank select. That is the register layout a neighbouring decoder expects, so every bit position can be checked directly. A behavioural reference model is stepped on every clock. With these widths the bench can reach the lock boundary, where the arm bit and the configuration bits change in the same write. It can also reach a hardware disarm that collides with a software arm, and each alignment code with the trace stub both idle and running.

// File: rtl/dbg_arm_pkg.sv
// Package: shared types for the debug arm/trigger register.
// Assumes: alignment field is 2 bits wide; code 11 behaves like end alignment.
package dbg_arm_pkg;
    typedef enum logic [1:0] {
        ALIGN_END   = 2'b00,
        ALIGN_BEGIN = 2'b01,
        ALIGN_MID   = 2'b10,
        ALIGN_RSVD  = 2'b11
    } trc_align_e;

    // True when a trigger under this alignment starts the capture immediately.
    function automatic logic align_starts_trace(input logic [1:0] a);
        return (a == ALIGN_BEGIN) || (a == ALIGN_MID);
    endfunction
endpackage

// File: rtl/dbg_arm_core.sv
// Module: arm flag with hardware-disarm priority and the State1 entry pulse.
// Assumes: wr_en_i is a qualified single-cycle write strobe.
module dbg_arm_core (
    input  logic clk,
    input  logic rst_n,
    input  logic wr_en_i,
    input  logic wr_arm_i,
    input  logic hw_disarm_i,
    output logic arm_o,
    output logic arm_next_o,
    output logic s1_pulse_o
);
    logic arm_q;
    logic s1_q;

    // Next arm value: a hardware disarm overrides any software write.
    always_comb begin
        if (hw_disarm_i)  arm_next_o = 1'b0;
        else if (wr_en_i) arm_next_o = wr_arm_i;
        else              arm_next_o = arm_q;
    end

    // Arm flag register and rising-edge State1 pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            arm_q <= 1'b0;
            s1_q  <= 1'b0;
        end else begin
            arm_q <= arm_next_o;
            s1_q  <= arm_next_o & ~arm_q;
        end
    end

    assign arm_o      = arm_q;
    assign s1_pulse_o = s1_q;

    // R6: a hardware disarm always leaves the flag clear.
    a_r6_hw_disarm: assert property (@(posedge clk) disable iff (!rst_n)
        hw_disarm_i |=> !arm_q);
    // R7: the State1 pulse only follows a 0 -> 1 change of the flag.
    a_r7_s1_on_rise: assert property (@(posedge clk) disable iff (!rst_n)
        s1_q |-> (arm_q && !$past(arm_q)));
endmodule

// File: rtl/dbg_arm_cfg.sv
// Module: configuration field (locked while armed) and bank select (always writable).
// Assumes: arm_i is the registered arm flag from before the current write.
module dbg_arm_cfg #(
    parameter int CFG_W  = 4,
    parameter int BANK_W = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en_i,
    input  logic              arm_i,
    input  logic [CFG_W-1:0]  wr_cfg_i,
    input  logic [BANK_W-1:0] wr_bank_i,
    output logic [CFG_W-1:0]  cfg_o,
    output logic [BANK_W-1:0] bank_o
);
    logic [CFG_W-1:0]  cfg_q;
    logic [BANK_W-1:0] bank_q;
    logic              cfg_we;

    // Configuration write enable: the lock uses the flag from before the write.
    assign cfg_we = wr_en_i & ~arm_i;

    // Field registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cfg_q  <= '0;
            bank_q <= '0;
        end else begin
            if (cfg_we)  cfg_q  <= wr_cfg_i;
            if (wr_en_i) bank_q <= wr_bank_i;
        end
    end

    assign cfg_o  = cfg_q;
    assign bank_o = bank_q;

    // R4: configuration holds across any cycle that starts armed.
    a_r4_cfg_locked: assert property (@(posedge clk) disable iff (!rst_n)
        arm_i |=> $stable(cfg_q));
endmodule

// File: rtl/dbg_trig_gate.sv
// Module: immediate-trigger gating and the trace-running stub.
// Assumes: trig_wr_i is already qualified by a register write.
module dbg_trig_gate
    import dbg_arm_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       trig_wr_i,
    input  logic       secure_i,
    input  logic       trc_en_i,
    input  logic [1:0] trc_align_i,
    input  logic       trace_done_i,
    input  logic       arm_next_i,
    output logic       trig_o,
    output logic       run_o
);
    logic fire;
    logic trig_q;
    logic run_q;

    // A trigger fires unless secure mode is on or a capture is already running.
    assign fire = trig_wr_i & ~secure_i & ~run_q;

    // Trigger pulse and trace-running stub.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            trig_q <= 1'b0;
            run_q  <= 1'b0;
        end else begin
            trig_q <= fire;
            if (trace_done_i || !arm_next_i)
                run_q <= 1'b0;
            else if (fire && trc_en_i && align_starts_trace(trc_align_i))
                run_q <= 1'b1;
        end
    end

    assign trig_o = trig_q;
    assign run_o  = run_q;

    // R9: secure mode suppresses the trigger.
    a_r9_secure_blocks: assert property (@(posedge clk) disable iff (!rst_n)
        (trig_wr_i && secure_i) |=> !trig_q);
    // R10: no trigger pulse follows a cycle with a capture running.
    a_r10_running_blocks: assert property (@(posedge clk) disable iff (!rst_n)
        run_q |=> !trig_q);
    // R11: trace completion clears the running flag.
    a_r11_done_clears: assert property (@(posedge clk) disable iff (!rst_n)
        trace_done_i |=> !run_q);
endmodule

// File: rtl/dbg_arm_ctl.sv
// Module: top of the debug arm/trigger control register.
// Layout: [REG_W-1] arm, [REG_W-2] trigger (write-only), then cfg, then bank at LSBs.
// Assumes: single register behind reg_sel_i; read data is combinational.
module dbg_arm_ctl #(
    parameter int CFG_W  = 4,
    parameter int BANK_W = 2,
    localparam int REG_W = CFG_W + BANK_W + 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_sel_i,
    input  logic              reg_wr_i,
    input  logic [REG_W-1:0]  reg_wdata_i,
    output logic [REG_W-1:0]  reg_rdata_o,
    input  logic              trace_done_i,
    input  logic              brk_notrace_i,
    input  logic              secure_i,
    input  logic              trc_en_i,
    input  logic [1:0]        trc_align_i,
    output logic              armed_o,
    output logic              trig_req_o,
    output logic              seq_s1_o,
    output logic [CFG_W-1:0]  cfg_o,
    output logic [BANK_W-1:0] bank_o,
    output logic              trc_running_o
);
    localparam int ARM_BIT  = REG_W - 1;
    localparam int TRIG_BIT = REG_W - 2;
    localparam int CFG_LSB  = BANK_W;

    logic wr_en;
    logic arm_next;

    // Qualified register write.
    assign wr_en = reg_sel_i & reg_wr_i;

    dbg_arm_core u_core (
        .clk         (clk),
        .rst_n       (rst_n),
        .wr_en_i     (wr_en),
        .wr_arm_i    (reg_wdata_i[ARM_BIT]),
        .hw_disarm_i (trace_done_i | brk_notrace_i),
        .arm_o       (armed_o),
        .arm_next_o  (arm_next),
        .s1_pulse_o  (seq_s1_o)
    );

    dbg_arm_cfg #(.CFG_W(CFG_W), .BANK_W(BANK_W)) u_cfg (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en_i   (wr_en),
        .arm_i     (armed_o),
        .wr_cfg_i  (reg_wdata_i[CFG_LSB +: CFG_W]),
        .wr_bank_i (reg_wdata_i[BANK_W-1:0]),
        .cfg_o     (cfg_o),
        .bank_o    (bank_o)
    );

    dbg_trig_gate u_trig (
        .clk          (clk),
        .rst_n        (rst_n),
        .trig_wr_i    (wr_en & reg_wdata_i[TRIG_BIT]),
        .secure_i     (secure_i),
        .trc_en_i     (trc_en_i),
        .trc_align_i  (trc_align_i),
        .trace_done_i (trace_done_i),
        .arm_next_i   (arm_next),
        .trig_o       (trig_req_o),
        .run_o        (trc_running_o)
    );

    // Read mux: the trigger position always reads 0.
    always_comb begin
        if (reg_sel_i) reg_rdata_o = {armed_o, 1'b0, cfg_o, bank_o};
        else           reg_rdata_o = '0;
    end

    // R3: a write without hardware disarm sets the flag to the written bit.
    a_r3_sw_arm: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !trace_done_i && !brk_notrace_i) |=> (armed_o == $past(reg_wdata_i[ARM_BIT])));
    // R8: a write with the trigger bit clear produces no pulse.
    a_r8_zero_no_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        (!(wr_en && reg_wdata_i[TRIG_BIT])) |=> !trig_req_o);
endmodule

// File: tb/dbg_arm_ctl_tb_top.sv
module dbg_arm_ctl_tb_top;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       sel = 0, wr = 0, done = 0, brk = 0, sec = 0, en = 0;
    logic [7:0] wdata = '0;
    logic [1:0] align = '0;
    logic [7:0] rdata;
    logic       armed, trig, s1, running;
    logic [3:0] cfg;
    logic [1:0] bank;

    int n_vec = 0;
    int n_bad = 0;

    // reference model state
    bit       m_arm, m_trig, m_s1, m_run;
    bit [3:0] m_cfg;
    bit [1:0] m_bank;

    always #5 clk = ~clk;

    dbg_arm_ctl dut_i (
        .clk(clk), .rst_n(rst_n), .reg_sel_i(sel), .reg_wr_i(wr),
        .reg_wdata_i(wdata), .reg_rdata_o(rdata), .trace_done_i(done),
        .brk_notrace_i(brk), .secure_i(sec), .trc_en_i(en), .trc_align_i(align),
        .armed_o(armed), .trig_req_o(trig), .seq_s1_o(s1), .cfg_o(cfg),
        .bank_o(bank), .trc_running_o(running)
    );

    task automatic chk(input string tag, input int act, input int exp);
        n_vec++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
        end
    endtask

    // compare every registered output against the model
    task automatic cmp_all();
        chk("R3/R6 armed", armed, m_arm);
        chk("R8/R9 trig", trig, m_trig);
        chk("R7 s1", s1, m_s1);
        chk("R4/R5 cfg", cfg, m_cfg);
        chk("R4 bank", bank, m_bank);
        chk("R10/R11 running", running, m_run);
    endtask

    // one clock: drive, check comb read, advance model, compare
    task automatic step(input bit s, input bit w, input bit [7:0] d,
                        input bit dn = 0, input bit bk = 0);
        bit we, n_arm, fire, n_run;
        sel = s; wr = w; wdata = d; done = dn; brk = bk;
        #1;
        chk("R2 rdata", rdata, s ? {m_arm, 1'b0, m_cfg, m_bank} : 8'h00);
        @(posedge clk);
        we    = s & w;
        n_arm = (dn | bk) ? 1'b0 : (we ? d[7] : m_arm);
        fire  = we & d[6] & ~sec & ~m_run;
        if (dn || !n_arm) n_run = 0;
        else if (fire && en && (align == 2'b01 || align == 2'b10)) n_run = 1;
        else n_run = m_run;
        m_s1 = n_arm & ~m_arm;
        if (we && !m_arm) m_cfg = d[5:2];
        if (we) m_bank = d[1:0];
        m_trig = fire;
        m_arm = n_arm;
        m_run = n_run;
        @(negedge clk);
        cmp_all();
    endtask

    initial begin : watchdog
        repeat (20000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog expired");
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        cmp_all();                               // R1 reset state
        chk("R1 rdata", rdata, 0);
        step(1, 0, 8'h00);                       // R2 read idle
        step(1, 1, 8'b0011_0110);                // R4 cfg written unarmed
        step(0, 0, 8'hFF);                       // R2 unselected reads 0
        step(1, 1, 8'b1010_1001);                // R3/R7 arm, cfg loaded
        step(1, 0, 8'h00);                       // R7 pulse gone
        step(1, 1, 8'b1011_1110);                // R4 cfg locked, bank moves
        step(1, 1, 8'b1000_0000);                // R8 trigger bit 0: no pulse
        step(1, 1, 8'b1100_0000);                // R8 trigger pulse
        step(1, 0, 8'h00);
        sec = 1;
        step(1, 1, 8'b1100_0000);                // R9 secure blocks
        sec = 0;
        en = 1; align = 2'b01;
        step(1, 1, 8'b1100_0000);                // R10 begin starts trace
        step(1, 1, 8'b1100_0000);                // R10 ignored while running
        step(1, 0, 8'h00, 1);                    // R6/R11 trace done disarms
        step(1, 0, 8'h00);
        step(1, 1, 8'b1000_0000, 0, 1);          // R6 brk beats sw arm
        step(1, 1, 8'b1000_0000);                // R7 arm again
        align = 2'b10;
        step(1, 1, 8'b1100_0000);                // R10 mid starts trace
        step(1, 1, 8'b0011_1100);                // R5/R11 sw disarm keeps cfg
        step(1, 1, 8'b0000_0000);                // R5 second write clears cfg
        align = 2'b00;
        step(1, 1, 8'b1100_0000);                // R10 end align no running
        step(1, 1, 8'b1100_0000);                // R8 trigger again
        step(1, 1, 8'b1000_0000, 0, 1);          // R6 brk while armed
        step(1, 0, 8'h00);
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end
endmodule